// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time and a calendar as seven packed-BCD byte registers: seconds, minutes, hours, day of month, month, weekday and a two-digit year. A free-running 32.768 kHz enable pulse is divided down inside the block by a binary prescaler to one step per second. Each step ripples through the fields with carries. The last day of every month is corrected for short months and for February in leap years.

The hours register runs in one of two encodings, chosen by its own top bit: a 24-hour count, or a 12-hour count with an afternoon flag. Bit 7 of the seconds register is a halt flag that freezes the whole counter. A host sets the time through a single-beat load port with a valid/ready handshake. Each beat carries a field selector and a data byte. The block never applies back-pressure: `ld_ready` is held high, so every beat with `ld_valid` high is taken on that clock edge and shows on the outputs after the edge. Loading the seconds register restarts the sub-second prescaler from zero.

Top module: `calendar_clock_top`

## Requirements
- R1: After reset the outputs read seconds 0x00, minutes 0x00, hours 0x00 (24-hour midnight), date 0x01, month 0x01, weekday 0x01 and year 0x00, and `ld_ready` is 1.
- R2: When not halted, the seconds advance by one for every 2^PRESC_BITS accepted enable pulses. Seconds and minutes count BCD 00..59, and each wraps to 00 with a carry into the next field.
- R3: With hours bit 7 = 0 (24-hour mode), bits 5:0 count BCD 00..23, bit 5 being the twenties digit. A step from 23:59:59 gives 00:00:00 and advances the date.
- R4: With hours bit 7 = 1 (12-hour mode), bit 5 = 1 means PM and bits 4:0 count BCD 01..12. The sequence is 11 AM (0x91) to 12 PM (0xB2) to 1 PM (0xA1), and 11 PM (0xB1) to 12 AM (0x92). The date advances only at the 11 PM to 12 AM step.
- R5: The date wraps to 01 and the month advances after day 30 in months 04, 06, 09 and 11. It does the same after day 28 of February in non-leap years, and after day 31 in all other months.
- R6: A year whose BCD value is divisible by four, 00 included, is a leap year, and February then runs to day 29.
- R7: Month 12 wraps to 01 with a carry into the year, and year 99 wraps to 00.
- R8: The weekday advances at each midnight and wraps from 07 to 01.
- R9: While seconds bit 7 is 1, no field changes except through a load. Clearing the bit resumes counting.
- R10: A seconds load clears the prescaler, so the next step comes exactly 2^PRESC_BITS enable pulses after the load.
- R11: A beat with `ld_valid` = 1 writes `ld_data` to the field picked by `ld_field`. The codes are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 weekday and 6 year. Code 7 changes nothing. An enable pulse arriving in a load cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | 32.768 kHz enable, one cycle wide |
| ld_valid | input | 1 | Load beat valid |
| ld_ready | output | 1 | Load beat ready (always 1) |
| ld_field | input | 3 | Field selector of the load beat |
| ld_data | input | 8 | BCD data of the load beat |
| sec_bcd | output | 8 | Halt flag (bit 7) and seconds |
| min_bcd | output | 8 | Minutes |
| hour_bcd | output | 8 | Mode, PM/twenties bit and hours |
| date_bcd | output | 8 | Day of month |
| month_bcd | output | 8 | Month |
| dow_bcd | output | 8 | Weekday 1..7 |
| year_bcd | output | 8 | Two-digit year |

## Verification
Directed runs start from loaded states one second before each rollover. These cover 23:59:59 in 24-hour mode, 11:59:59 AM and PM in 12-hour mode, the end of April and of February in years 23, 24 and 00, and 31 December 99, which together separate the month-length, leap and weekday paths. Separate runs hold the halt flag over many enable pulses and load seconds part way through a second, which shows whether the prescaler is frozen and cleared. A seeded random phase loads legal states in both hour modes, often close to rollover, and runs a random number of enable pulses against a bench model that counts in binary.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DATE  = 3'd3,
    FLD_MONTH = 3'd4,
    FLD_DOW   = 3'd5,
    FLD_YEAR  = 3'd6,
    FLD_NONE  = 3'd7
  } field_e;

  localparam int NUM_FIELDS = 7;

  typedef struct packed {
    logic       carry;
    logic [7:0] val;
  } bcd_res_t;

  // Two-digit BCD increment; at or beyond 'last' it wraps to 'first'.
  function automatic bcd_res_t bcd_step(input logic [7:0] v,
                                        input logic [7:0] last,
                                        input logic [7:0] first);
    bcd_res_t r;
    r.carry = 1'b0;
    if (v >= last) begin
      r.carry = 1'b1;
      r.val   = first;
    end else if (v[3:0] >= 4'd9) begin
      r.val = {v[7:4] + 4'd1, 4'h0};
    end else begin
      r.val = {v[7:4], v[3:0] + 4'd1};
    end
    return r;
  endfunction

  // Year divisible by four: even tens need units 0/4/8, odd tens 2/6.
  function automatic logic leap_year(input logic [7:0] y);
    if (y[4])
      return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else
      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] m,
                                            input logic       leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int BITS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic pulse
);
  localparam logic [BITS-1:0] LAST = '1;

  logic [BITS-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (en)  cnt_q <= cnt_q + 1'b1;
  end

  assign pulse = en && !clr && (cnt_q == LAST);
endmodule

// File: rtl/cal_time.sv
module cal_time
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       ld_sec,
  input  logic       ld_min,
  input  logic       ld_hour,
  input  logic [7:0] ld_data,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic       day_carry
);
  bcd_res_t   sec_r, min_r, hr_t;
  logic [7:0] hour_nx;
  logic       hr_carry;

  assign sec_r = bcd_step({1'b0, sec_q[6:0]}, 8'h59, 8'h00);
  assign min_r = bcd_step({1'b0, min_q[6:0]}, 8'h59, 8'h00);

  always_comb begin
    hour_nx  = hour_q;
    hr_carry = 1'b0;
    hr_t     = '0;
    if (hour_q[7]) begin
      if (hour_q[4:0] == 5'h11) begin
        hour_nx  = {1'b1, 1'b0, ~hour_q[5], 5'h12};
        hr_carry = hour_q[5];
      end else if (hour_q[4:0] >= 5'h12) begin
        hour_nx = {1'b1, 1'b0, hour_q[5], 5'h01};
      end else begin
        hr_t    = bcd_step({3'b000, hour_q[4:0]}, 8'h12, 8'h01);
        hour_nx = {1'b1, 1'b0, hour_q[5], hr_t.val[4:0]};
      end
    end else begin
      hr_t     = bcd_step({2'b00, hour_q[5:0]}, 8'h23, 8'h00);
      hour_nx  = {2'b00, hr_t.val[5:0]};
      hr_carry = hr_t.carry;
    end
  end

  assign day_carry = step && sec_r.carry && min_r.carry && hr_carry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else begin
      if (ld_sec)    sec_q <= ld_data;
      else if (step) sec_q <= {sec_q[7], sec_r.val[6:0]};

      if (ld_min)                    min_q <= {1'b0, ld_data[6:0]};
      else if (step && sec_r.carry)  min_q <= min_r.val;

      if (ld_hour)                                  hour_q <= {ld_data[7], 1'b0, ld_data[5:0]};
      else if (step && sec_r.carry && min_r.carry)  hour_q <= hour_nx;
    end
  end
endmodule

// File: rtl/cal_date.sv
module cal_date
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       ld_date,
  input  logic       ld_month,
  input  logic       ld_dow,
  input  logic       ld_year,
  input  logic [7:0] ld_data,
  output logic [7:0] date_q,
  output logic [7:0] month_q,
  output logic [7:0] dow_q,
  output logic [7:0] year_q
);
  bcd_res_t   date_r, month_r, year_r;
  logic [7:0] last_day;
  logic [7:0] dow_nx;

  assign last_day = month_last(month_q, leap_year(year_q));
  assign date_r   = bcd_step(date_q, last_day, 8'h01);
  assign month_r  = bcd_step(month_q, 8'h12, 8'h01);
  assign year_r   = bcd_step(year_q, 8'h99, 8'h00);
  assign dow_nx   = (dow_q >= 8'h07) ? 8'h01 : dow_q + 8'h01;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      date_q  <= 8'h01;
      month_q <= 8'h01;
      dow_q   <= 8'h01;
      year_q  <= 8'h00;
    end else begin
      if (ld_date)   date_q <= {2'b00, ld_data[5:0]};
      else if (step) date_q <= date_r.val;

      if (ld_month)                  month_q <= {3'b000, ld_data[4:0]};
      else if (step && date_r.carry) month_q <= month_r.val;

      if (ld_dow)    dow_q <= {5'b00000, ld_data[2:0]};
      else if (step) dow_q <= dow_nx;

      if (ld_year)                                    year_q <= ld_data;
      else if (step && date_r.carry && month_r.carry) year_q <= year_r.val;
    end
  end
endmodule

// File: rtl/calendar_clock_top.sv
module calendar_clock_top
  import cal_pkg::*;
#(
  parameter int PRESC_BITS = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic       ld_valid,
  output logic       ld_ready,
  input  logic [2:0] ld_field,
  input  logic [7:0] ld_data,
  output logic [7:0] sec_bcd,
  output logic [7:0] min_bcd,
  output logic [7:0] hour_bcd,
  output logic [7:0] date_bcd,
  output logic [7:0] month_bcd,
  output logic [7:0] dow_bcd,
  output logic [7:0] year_bcd
);
  logic                  wr_fire;
  logic [NUM_FIELDS-1:0] ld_sel;
  logic                  halted;
  logic                  presc_en;
  logic                  sec_pulse;
  logic                  day_carry;

  assign ld_ready = 1'b1;
  assign wr_fire  = ld_valid && ld_ready;
  assign halted   = sec_bcd[7];

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_ld_dec
    assign ld_sel[g] = wr_fire && (ld_field == 3'(g));
  end

  assign presc_en = tick_32k && !halted && !wr_fire;

  cal_prescaler #(.BITS(PRESC_BITS)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (presc_en),
    .clr   (ld_sel[FLD_SEC]),
    .pulse (sec_pulse)
  );

  cal_time u_time (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (sec_pulse),
    .ld_sec    (ld_sel[FLD_SEC]),
    .ld_min    (ld_sel[FLD_MIN]),
    .ld_hour   (ld_sel[FLD_HOUR]),
    .ld_data   (ld_data),
    .sec_q     (sec_bcd),
    .min_q     (min_bcd),
    .hour_q    (hour_bcd),
    .day_carry (day_carry)
  );

  cal_date u_date (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (day_carry),
    .ld_date  (ld_sel[FLD_DATE]),
    .ld_month (ld_sel[FLD_MONTH]),
    .ld_dow   (ld_sel[FLD_DOW]),
    .ld_year  (ld_sel[FLD_YEAR]),
    .ld_data  (ld_data),
    .date_q   (date_bcd),
    .month_q  (month_bcd),
    .dow_q    (dow_bcd),
    .year_q   (year_bcd)
  );
endmodule

// File: rtl/cal_checker.sv
module cal_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_fire,
  input logic [2:0] ld_field,
  input logic       sec_pulse,
  input logic [7:0] sec,
  input logic [7:0] min,
  input logic [7:0] hour,
  input logic [7:0] date,
  input logic [7:0] dow
);
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fire && sec[7]) |=> ($stable(sec) && $stable(min) && $stable(hour) && $stable(date) && $stable(dow))); // R9

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && sec[6:0] == 7'h59) |=> (sec[6:0] == 7'h00)); // R2

  AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fire && !(sec_pulse && sec[6:0] == 7'h59)) |=> $stable(min)); // R2

  AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && sec[6:0] == 7'h59 && min == 8'h59 && hour == 8'h23 && dow == 8'h07) |=> (dow == 8'h01)); // R8

  AST_PRESC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && ld_field == 3'd0) |=> !sec_pulse); // R10

  AST_DATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fire && !sec_pulse) |=> $stable(date)); // R11
endmodule

bind calendar_clock_top cal_checker u_cal_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_fire   (wr_fire),
  .ld_field  (ld_field),
  .sec_pulse (sec_pulse),
  .sec       (sec_bcd),
  .min       (min_bcd),
  .hour      (hour_bcd),
  .date      (date_bcd),
  .dow       (dow_bcd)
);

// File: tb/test_calendar_clock_top.sv
module test_calendar_clock_top;
  localparam int P    = 3;
  localparam int PMAX = (1 << P) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32k = 1'b0;
  logic       ld_valid = 1'b0;
  logic       ld_ready;
  logic [2:0] ld_field = 3'd0;
  logic [7:0] ld_data = 8'h00;
  logic [7:0] sec_bcd, min_bcd, hour_bcd, date_bcd, month_bcd, dow_bcd, year_bcd;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] ms, mm, mh, md, mmo, mw, my;
  int pc = 0;

  always #10 clk = ~clk;

  calendar_clock_top #(.PRESC_BITS(P)) i_calendar_clock_top (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_field(ld_field), .ld_data(ld_data),
    .sec_bcd(sec_bcd), .min_bcd(min_bcd), .hour_bcd(hour_bcd), .date_bcd(date_bcd),
    .month_bcd(month_bcd), .dow_bcd(dow_bcd), .year_bcd(year_bcd)
  );

  function automatic int b2i(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int n);
    logic [7:0] r;
    r[7:4] = 4'(n / 10);
    r[3:0] = 4'(n % 10);
    return r;
  endfunction

  function automatic int dim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_second();
    int s, mi, h, d, mo, y;
    bit pm, carry;
    s = b2i({1'b0, ms[6:0]});
    if (s != 59) begin ms = (ms & 8'h80) | i2b(s + 1); return; end
    ms = ms & 8'h80;
    mi = b2i(mm);
    if (mi != 59) begin mm = i2b(mi + 1); return; end
    mm = 8'h00;
    carry = 1'b0;
    if (mh[7]) begin
      pm = mh[5];
      h  = b2i({3'b000, mh[4:0]});
      if (h == 11) begin h = 12; carry = pm; pm = !pm; end
      else if (h == 12) h = 1;
      else h = h + 1;
      mh = 8'h80 | (pm ? 8'h20 : 8'h00) | i2b(h);
    end else begin
      h = b2i({2'b00, mh[5:0]});
      if (h == 23) begin h = 0; carry = 1'b1; end else h = h + 1;
      mh = i2b(h);
    end
    if (!carry) return;
    mw = (mw == 8'h07) ? 8'h01 : mw + 8'h01;
    d = b2i(md); mo = b2i(mmo); y = b2i(my);
    if (d >= dim(mo, y)) begin
      d = 1;
      if (mo == 12) begin mo = 1; y = (y == 99) ? 0 : y + 1; end
      else mo = mo + 1;
    end else d = d + 1;
    md = i2b(d); mmo = i2b(mo); my = i2b(y);
  endtask

  task automatic model_enable();
    if (ms[7]) return;
    if (pc == PMAX) begin pc = 0; model_second(); end
    else pc = pc + 1;
  endtask

  task automatic check_all(input string tag);
    logic [55:0] act, exp;
    act = {sec_bcd, min_bcd, hour_bcd, date_bcd, month_bcd, dow_bcd, year_bcd};
    exp = {ms, mm, mh, md, mmo, mw, my};
    checks++;
    if (act !== exp || ld_ready !== 1'b1) begin
      fails++;
      $display("FAIL %s: actual %h ready %b expected %h ready 1", tag, act, ld_ready, exp);
    end
  endtask

  task automatic do_load(input logic [2:0] f, input logic [7:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_field = f; ld_data = d;
    case (f)
      3'd0: begin ms = d; pc = 0; end
      3'd1: mm = {1'b0, d[6:0]};
      3'd2: mh = d & 8'hBF;
      3'd3: md = d & 8'h3F;
      3'd4: mmo = d & 8'h1F;
      3'd5: mw = d & 8'h07;
      3'd6: my = d;
      default: ;
    endcase
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_32k = 1'b1;
      model_enable();
    end
    @(negedge clk);
    tick_32k = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                         input logic [7:0] d, input logic [7:0] mo, input logic [7:0] w,
                         input logic [7:0] y);
    do_load(3'd1, mi); do_load(3'd2, h); do_load(3'd3, d);
    do_load(3'd4, mo); do_load(3'd5, w); do_load(3'd6, y);
    do_load(3'd0, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R2 watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    ms = 8'h00; mm = 8'h00; mh = 8'h00; md = 8'h01; mmo = 8'h01; mw = 8'h01; my = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset state");

    run_ticks(3 * (PMAX + 1));
    check_all("R2 three seconds from reset");
    run_ticks(PMAX);
    check_all("R2 one enable short of a step");

    set_all(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h07, 8'h23);
    run_ticks(PMAX + 1);
    check_all("R3 R5 R8 midnight Feb 28 non-leap to Mar 01, weekday 7 to 1");

    set_all(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h03, 8'h24);
    run_ticks(PMAX + 1);
    check_all("R6 Feb 28 in year 24 to Feb 29");
    run_ticks(24 * 3600 * (PMAX + 1) / 24 / 3600);
    set_all(8'h59, 8'h59, 8'h23, 8'h29, 8'h02, 8'h04, 8'h24);
    run_ticks(PMAX + 1);
    check_all("R6 Feb 29 year 24 to Mar 01");

    set_all(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h01, 8'h00);
    run_ticks(PMAX + 1);
    check_all("R6 year 00 is leap");

    set_all(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h02, 8'h10);
    run_ticks(PMAX + 1);
    check_all("R5 Apr 30 to May 01");

    set_all(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h05, 8'h99);
    run_ticks(PMAX + 1);
    check_all("R7 Dec 31 99 to Jan 01 00");

    set_all(8'h59, 8'h59, 8'h91, 8'h10, 8'h06, 8'h02, 8'h30);
    run_ticks(PMAX + 1);
    check_all("R4 11 AM to 12 PM, date held");
    set_all(8'h59, 8'h59, 8'hB2, 8'h10, 8'h06, 8'h02, 8'h30);
    run_ticks(PMAX + 1);
    check_all("R4 12 PM to 1 PM");
    set_all(8'h59, 8'h59, 8'hB1, 8'h10, 8'h06, 8'h02, 8'h30);
    run_ticks(PMAX + 1);
    check_all("R4 11 PM to 12 AM, date advances");
    set_all(8'h59, 8'h59, 8'h09, 8'h10, 8'h06, 8'h02, 8'h30);
    run_ticks(PMAX + 1);
    check_all("R3 09:59:59 to 10:00:00 in 24-hour mode");

    do_load(3'd0, 8'hB0);
    run_ticks(5 * (PMAX + 1));
    check_all("R9 halted counter frozen");
    do_load(3'd0, 8'h30);
    run_ticks(PMAX + 1);
    check_all("R9 counting resumes after halt cleared");

    run_ticks(PMAX - 2);
    do_load(3'd0, 8'h40);
    run_ticks(PMAX);
    check_all("R10 no step one enable before a full period after seconds load");
    run_ticks(1);
    check_all("R10 step exactly one period after seconds load");

    do_load(3'd7, 8'h55);
    check_all("R11 field code 7 changes nothing");
    do_load(3'd1, 8'h42);
    check_all("R11 minutes load");
    @(negedge clk);
    ld_valid = 1'b1; ld_field = 3'd7; ld_data = 8'h00; tick_32k = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0; tick_32k = 1'b0;
    run_ticks(PMAX);
    check_all("R11 enable in load cycle not counted");

    for (int it = 0; it < 40; it++) begin
      int mo, y, n;
      logic [7:0] hv;
      mo = int'($urandom_range(12, 1));
      y  = int'($urandom_range(99, 0));
      if ($urandom_range(1, 0) == 1)
        hv = 8'h80 | ($urandom_range(1, 0) == 1 ? 8'h20 : 8'h00) | i2b(int'($urandom_range(12, 1)));
      else
        hv = i2b(int'($urandom_range(23, 0)));
      set_all(i2b(int'($urandom_range(59, 50))) | ($urandom_range(9, 0) == 0 ? 8'h80 : 8'h00),
              ($urandom_range(1, 0) == 1) ? 8'h59 : i2b(int'($urandom_range(59, 0))),
              hv, i2b(int'($urandom_range(dim(mo, y), dim(mo, y) - 1))), i2b(mo),
              i2b(int'($urandom_range(7, 1))), i2b(y));
      n = int'($urandom_range(300, 1));
      run_ticks(n);
      check_all("R2 random run");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule